// File: doc/BRIEF.md
# Sequential Stream Data Prefetcher

This block sits beside a level-one data cache. It watches load references by cache-line index and spots runs of misses that walk through memory one line at a time, in either direction. A miss that belongs to no known run is parked in a small candidate table. A later miss exactly one line above or below a parked entry turns it into a tracked stream. Eight streams can be tracked at the same time.

Each time a load reaches the line a stream expects next, the stream moves one line forward. The block then issues two requests. A near request asks the level-one cache for the following line in the stream's direction. A far request asks for a memory-to-level-two transfer of the line twelve lines beyond the referenced one. The near requests and the far requests leave on separate valid/ready ports, and each port has a two-entry queue.

A stream never leaves its 4 KB page. It is freed as soon as its next line would fall in another page. A far request that would leave the page is not issued.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset no request is valid on either port, and no stream or candidate exists.
- R2: A miss on line L+1 while line L is a valid candidate confirms an ascending stream. The next cycle offers near line L+2 and far line L+1+12.
- R3: A miss on line L-1 while line L is a valid candidate confirms a descending stream, with near line L-2 and far line L-1-12. When both neighbours are candidates, ascending wins.
- R4: A reference to a stream's expected line L advances that stream, whether or not the reference missed. For an ascending stream it requests near L+1 and far L+12, and the expected line becomes L+1. A descending stream mirrors this. If several streams expect the same line, the lowest-numbered slot is the one that advances.
- R5: A reference that matches no stream's expected line and is not marked as a miss changes nothing. It issues no request and inserts no candidate.
- R6: A page is the line index with its low 6 bits dropped (64-byte lines, 4 KB pages). When the next line lies in another page, an advancing stream is freed and issues nothing. A confirming pair in the same position allocates no stream and issues nothing, but its candidate is still consumed.
- R7: A far target that lies outside the page of the referenced line is not requested, while the near request is still issued.
- R8: A confirmed stream takes the lowest free slot among eight. When all slots are in use, it replaces the least recently allocated-or-advanced stream.
- R9: The candidate table has four entries, replaced in round-robin order. A miss already present as a candidate is not inserted again. The candidate that confirms a stream is removed.
- R10: Each port presents its oldest queued request and holds it stable until accepted. A request produced while that port's queue already holds two requests is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A load reference is presented this cycle |
| refLine | input | 26 | Cache-line index of the reference |
| refMiss | input | 1 | The reference missed the level-one cache |
| nearValid | output | 1 | Level-one prefetch request valid |
| nearReady | input | 1 | Level-one prefetch request accepted |
| nearLine | output | 26 | Line index to prefetch into level one |
| farValid | output | 1 | Memory-to-level-two request valid |
| farReady | input | 1 | Memory-to-level-two request accepted |
| farLine | output | 26 | Line index to move from memory into level two |

## Verification
The bench targets pairs of lines that straddle a page edge. A design that ignores the page edge keeps prefetching into the next page, or leaves a dead stream in a slot. It fills all eight slots, touches the oldest stream, and then confirms a ninth. A design with a wrong age order evicts the stream that was just used, and that stream's next reference then produces nothing. It stalls both ports and lets three requests pile up: a broken queue would overwrite its head or hold more than two. Random walks in both directions over a few pages also mix non-miss references and duplicate candidates, which would expose a design that inserts candidates too eagerly.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Strobes from the decision logic to the tables and queues.
  typedef struct packed {
    logic hit;         // advance the matched stream
    logic retire;      // free the matched stream
    logic alloc;       // open a new stream
    logic dirDown;     // direction used for address generation
    logic candClear;   // consume the matching candidate
    logic candInsert;  // park the reference as a candidate
    logic pushNear;    // enqueue a level-one prefetch
    logic pushFar;     // enqueue a memory-to-level-two request
  } pf_ctl_t;

endpackage

// File: rtl/pf_reqq.sv
module pf_reqq #(
  parameter int DATA_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  logic [1:0]        count;
  logic [DATA_W-1:0] head;
  logic [DATA_W-1:0] tail;
  logic              doPop;
  logic              doPush;

  assign doPop    = (count != 2'd0) && outReady;
  assign doPush   = push && (count != 2'd2);
  assign outValid = (count != 2'd0);
  assign outData  = head;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= 2'd0;
      head  <= '0;
      tail  <= '0;
    end else begin
      if (doPop) head <= tail;
      if (doPush) begin
        if (count == 2'd0 || (count == 2'd1 && doPop)) head <= pushData;
        else tail <= pushData;
      end
      count <= count + {1'b0, doPush} - {1'b0, doPop};
    end
  end

endmodule

// File: rtl/pf_datapath.sv
module pf_datapath
  import pf_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int PAGE_OFS_W  = 6,
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CANDS   = 4,
  parameter int FAR_DIST    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] refLine,
  input  pf_ctl_t           ctl,
  output logic              hitAny,
  output logic              hitDown,
  output logic              ascAny,
  output logic              descAny,
  output logic              candDup,
  output logic              crossUp,
  output logic              crossDown,
  output logic              farCrossUp,
  output logic              farCrossDown,
  output logic [LINE_W-1:0] nearLine,
  output logic [LINE_W-1:0] farLine
);

  localparam int SIDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
  localparam int CIDX_W = (NUM_CANDS > 1) ? $clog2(NUM_CANDS) : 1;
  localparam int PAGE_W = LINE_W - PAGE_OFS_W;
  localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);
  localparam logic [LINE_W-1:0] FAR_L = LINE_W'(FAR_DIST);
  localparam logic [SIDX_W-1:0] OLDEST = SIDX_W'(NUM_STREAMS - 1);
  localparam logic [CIDX_W-1:0] LAST_CAND = CIDX_W'(NUM_CANDS - 1);

  // stream table
  logic              sValid [NUM_STREAMS];
  logic [LINE_W-1:0] sNext  [NUM_STREAMS];
  logic              sDown  [NUM_STREAMS];
  logic [SIDX_W-1:0] sAge   [NUM_STREAMS];

  // candidate table
  logic              cValid [NUM_CANDS];
  logic [LINE_W-1:0] cLine  [NUM_CANDS];
  logic [CIDX_W-1:0] cPtr;

  logic [NUM_STREAMS-1:0] hitVec;
  logic [NUM_STREAMS-1:0] freeVec;
  logic [NUM_STREAMS-1:0] oldVec;
  logic [NUM_CANDS-1:0]   ascVec;
  logic [NUM_CANDS-1:0]   descVec;
  logic [NUM_CANDS-1:0]   dupVec;

  logic [SIDX_W-1:0] hitIdx;
  logic [SIDX_W-1:0] allocIdx;
  logic [CIDX_W-1:0] ascIdx;
  logic [CIDX_W-1:0] descIdx;
  logic [CIDX_W-1:0] clrIdx;
  logic              anyFree;

  logic [LINE_W-1:0] lineUp;
  logic [LINE_W-1:0] lineDn;
  logic [LINE_W-1:0] farUp;
  logic [LINE_W-1:0] farDn;
  logic [PAGE_W-1:0] refPage;

  // ---------------- address generation ----------------
  assign lineUp  = refLine + ONE_L;
  assign lineDn  = refLine - ONE_L;
  assign farUp   = refLine + FAR_L;
  assign farDn   = refLine - FAR_L;
  assign refPage = refLine[LINE_W-1:PAGE_OFS_W];

  assign crossUp      = (lineUp[LINE_W-1:PAGE_OFS_W] != refPage);
  assign crossDown    = (lineDn[LINE_W-1:PAGE_OFS_W] != refPage);
  assign farCrossUp   = (farUp[LINE_W-1:PAGE_OFS_W]  != refPage);
  assign farCrossDown = (farDn[LINE_W-1:PAGE_OFS_W]  != refPage);

  assign nearLine = ctl.dirDown ? lineDn : lineUp;
  assign farLine  = ctl.dirDown ? farDn  : farUp;

  // ---------------- per-slot comparators ----------------
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gSlotCmp
    assign hitVec[g]  = sValid[g] && (sNext[g] == refLine);
    assign freeVec[g] = !sValid[g];
    assign oldVec[g]  = sValid[g] && (sAge[g] == OLDEST);
  end

  for (genvar g = 0; g < NUM_CANDS; g++) begin : gCandCmp
    assign ascVec[g]  = cValid[g] && (cLine[g] == lineDn);
    assign descVec[g] = cValid[g] && (cLine[g] == lineUp);
    assign dupVec[g]  = cValid[g] && (cLine[g] == refLine);
  end

  // ---------------- priority selection ----------------
  always_comb begin
    hitAny   = 1'b0;
    hitIdx   = '0;
    anyFree  = 1'b0;
    allocIdx = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (!hitAny && hitVec[i]) begin
        hitAny = 1'b1;
        hitIdx = SIDX_W'(i);
      end
      if (!anyFree && freeVec[i]) begin
        anyFree  = 1'b1;
        allocIdx = SIDX_W'(i);
      end
    end
    if (!anyFree) begin
      for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
        if (oldVec[i]) allocIdx = SIDX_W'(i);
      end
    end
  end

  assign hitDown = sDown[hitIdx];

  always_comb begin
    ascAny  = 1'b0;
    descAny = 1'b0;
    ascIdx  = '0;
    descIdx = '0;
    for (int i = 0; i < NUM_CANDS; i++) begin
      if (!ascAny && ascVec[i]) begin
        ascAny = 1'b1;
        ascIdx = CIDX_W'(i);
      end
      if (!descAny && descVec[i]) begin
        descAny = 1'b1;
        descIdx = CIDX_W'(i);
      end
    end
  end

  assign candDup = |dupVec;
  assign clrIdx  = ctl.dirDown ? descIdx : ascIdx;

  // ---------------- stream table update ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        sValid[i] <= 1'b0;
        sNext[i]  <= '0;
        sDown[i]  <= 1'b0;
        sAge[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if (ctl.alloc) begin
          if (allocIdx == SIDX_W'(i)) begin
            sValid[i] <= 1'b1;
            sNext[i]  <= nearLine;
            sDown[i]  <= ctl.dirDown;
            sAge[i]   <= '0;
          end else if (sValid[i]) begin
            sAge[i] <= sAge[i] + SIDX_W'(1);
          end
        end
        if (ctl.hit) begin
          if (hitIdx == SIDX_W'(i)) begin
            sNext[i] <= nearLine;
            sAge[i]  <= '0;
          end else if (sValid[i] && (sAge[i] < sAge[hitIdx])) begin
            sAge[i] <= sAge[i] + SIDX_W'(1);
          end
        end
        if (ctl.retire) begin
          if (hitIdx == SIDX_W'(i)) begin
            sValid[i] <= 1'b0;
          end else if (sValid[i] && (sAge[i] > sAge[hitIdx])) begin
            sAge[i] <= sAge[i] - SIDX_W'(1);
          end
        end
      end
    end
  end

  // ---------------- candidate table update ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cPtr <= '0;
      for (int i = 0; i < NUM_CANDS; i++) begin
        cValid[i] <= 1'b0;
        cLine[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CANDS; i++) begin
        if (ctl.candClear && clrIdx == CIDX_W'(i)) cValid[i] <= 1'b0;
        if (ctl.candInsert && cPtr == CIDX_W'(i)) begin
          cValid[i] <= 1'b1;
          cLine[i]  <= refLine;
        end
      end
      if (ctl.candInsert) cPtr <= (cPtr == LAST_CAND) ? '0 : cPtr + CIDX_W'(1);
    end
  end

endmodule

// File: rtl/pf_control.sv
module pf_control
  import pf_pkg::*;
(
  input  logic    refValid,
  input  logic    refMiss,
  input  logic    hitAny,
  input  logic    hitDown,
  input  logic    ascAny,
  input  logic    descAny,
  input  logic    candDup,
  input  logic    crossUp,
  input  logic    crossDown,
  input  logic    farCrossUp,
  input  logic    farCrossDown,
  output pf_ctl_t ctl
);

  logic matchRef;
  logic confirmRef;
  logic dirDown;
  logic crossNext;
  logic crossFar;
  logic issue;

  always_comb begin
    matchRef   = refValid && hitAny;
    confirmRef = refValid && !hitAny && refMiss && (ascAny || descAny);
    dirDown    = matchRef ? hitDown : !ascAny;
    crossNext  = dirDown ? crossDown : crossUp;
    crossFar   = dirDown ? farCrossDown : farCrossUp;
    issue      = (matchRef || confirmRef) && !crossNext;

    ctl            = '0;
    ctl.dirDown    = dirDown;
    ctl.hit        = matchRef && !crossNext;
    ctl.retire     = matchRef && crossNext;
    ctl.alloc      = confirmRef && !crossNext;
    ctl.candClear  = confirmRef;
    ctl.candInsert = refValid && refMiss && !hitAny && !ascAny && !descAny && !candDup;
    ctl.pushNear   = issue;
    ctl.pushFar    = issue && !crossFar;
  end

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import pf_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int PAGE_OFS_W  = 6,
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CANDS   = 4,
  parameter int FAR_DIST    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refValid,
  input  logic [LINE_W-1:0] refLine,
  input  logic              refMiss,
  output logic              nearValid,
  input  logic              nearReady,
  output logic [LINE_W-1:0] nearLine,
  output logic              farValid,
  input  logic              farReady,
  output logic [LINE_W-1:0] farLine
);

  localparam int NUM_PORTS = 2;

  pf_ctl_t           ctl;
  logic              hitAny, hitDown, ascAny, descAny, candDup;
  logic              crossUp, crossDown, farCrossUp, farCrossDown;
  logic [LINE_W-1:0] genNear, genFar;

  logic              qPush  [NUM_PORTS];
  logic [LINE_W-1:0] qIn    [NUM_PORTS];
  logic              qValid [NUM_PORTS];
  logic              qReady [NUM_PORTS];
  logic [LINE_W-1:0] qOut   [NUM_PORTS];

  pf_datapath #(
    .LINE_W(LINE_W), .PAGE_OFS_W(PAGE_OFS_W), .NUM_STREAMS(NUM_STREAMS),
    .NUM_CANDS(NUM_CANDS), .FAR_DIST(FAR_DIST)
  ) uDp (
    .clk(clk), .rstN(rstN), .refLine(refLine), .ctl(ctl),
    .hitAny(hitAny), .hitDown(hitDown), .ascAny(ascAny), .descAny(descAny),
    .candDup(candDup), .crossUp(crossUp), .crossDown(crossDown),
    .farCrossUp(farCrossUp), .farCrossDown(farCrossDown),
    .nearLine(genNear), .farLine(genFar)
  );

  pf_control uCtl (
    .refValid(refValid), .refMiss(refMiss), .hitAny(hitAny), .hitDown(hitDown),
    .ascAny(ascAny), .descAny(descAny), .candDup(candDup),
    .crossUp(crossUp), .crossDown(crossDown),
    .farCrossUp(farCrossUp), .farCrossDown(farCrossDown), .ctl(ctl)
  );

  assign qPush[0]  = ctl.pushNear;
  assign qIn[0]    = genNear;
  assign qReady[0] = nearReady;
  assign qPush[1]  = ctl.pushFar;
  assign qIn[1]    = genFar;
  assign qReady[1] = farReady;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    pf_reqq #(.DATA_W(LINE_W)) uQ (
      .clk(clk), .rstN(rstN), .push(qPush[p]), .pushData(qIn[p]),
      .outValid(qValid[p]), .outReady(qReady[p]), .outData(qOut[p])
    );
  end

  assign nearValid = qValid[0];
  assign nearLine  = qOut[0];
  assign farValid  = qValid[1];
  assign farLine   = qOut[1];

endmodule

// File: rtl/stream_prefetcher_chk.sv
module stream_prefetcher_chk #(
  parameter int LINE_W   = 26,
  parameter int FAR_DIST = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              refValid,
  input logic [LINE_W-1:0] refLine,
  input logic              nearValid,
  input logic              nearReady,
  input logic [LINE_W-1:0] nearLine,
  input logic              farValid,
  input logic              farReady,
  input logic [LINE_W-1:0] farLine
);

  localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);
  localparam logic [LINE_W-1:0] FAR_L = LINE_W'(FAR_DIST);

  AST_NEAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    nearValid && !nearReady |=> nearValid && $stable(nearLine)); // R10

  AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    farValid && !farReady |=> farValid && $stable(farLine)); // R10

  AST_NEAR_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rstN)
    !nearValid && refValid |=> !nearValid ||
      nearLine == LINE_W'($past(refLine) + ONE_L) ||
      nearLine == LINE_W'($past(refLine) - ONE_L)); // R4

  AST_FAR_DISTANCE: assert property (@(posedge clk) disable iff (!rstN)
    !farValid && refValid |=> !farValid ||
      farLine == LINE_W'($past(refLine) + FAR_L) ||
      farLine == LINE_W'($past(refLine) - FAR_L)); // R4

  AST_NEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !nearValid && !refValid |=> !nearValid); // R5

  AST_FAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !farValid && !refValid |=> !farValid); // R5

endmodule

bind stream_prefetcher stream_prefetcher_chk #(
  .LINE_W(LINE_W), .FAR_DIST(FAR_DIST)
) uChk (
  .clk(clk), .rstN(rstN), .refValid(refValid), .refLine(refLine),
  .nearValid(nearValid), .nearReady(nearReady), .nearLine(nearLine),
  .farValid(farValid), .farReady(farReady), .farLine(farLine)
);

// File: tb/sim_stream_prefetcher.sv
`timescale 1ns/1ps
module sim_stream_prefetcher;

  localparam int LW = 26;
  localparam int PO = 6;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int FD = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refValid = 1'b0;
  logic [LW-1:0] refLine = '0;
  logic          refMiss = 1'b0;
  logic          nearValid, farValid;
  logic          nearReady = 1'b1, farReady = 1'b1;
  logic [LW-1:0] nearLine, farLine;

  always #4 clk = ~clk;  // 125 MHz

  stream_prefetcher u0 (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refLine(refLine), .refMiss(refMiss),
    .nearValid(nearValid), .nearReady(nearReady), .nearLine(nearLine),
    .farValid(farValid), .farReady(farReady), .farLine(farLine)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";

  // ---------------- reference model ----------------
  logic          mV [NS];
  logic [LW-1:0] mN [NS];
  logic          mD [NS];
  int            mSt[NS];
  int            stampCtr = 0;
  logic          cV [NC];
  logic [LW-1:0] cL [NC];
  int            cPtr = 0;
  logic [LW-1:0] qN [2];
  int            qNc = 0;
  logic [LW-1:0] qF [2];
  int            qFc = 0;

  function automatic logic [LW-PO-1:0] pg(input logic [LW-1:0] a);
    return a[LW-1:PO];
  endfunction

  task automatic check(input logic ok, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic issue(input logic dir, input logic [LW-1:0] ln, input logic [LW-1:0] nx,
                       output logic pn, output logic pf,
                       output logic [LW-1:0] dn, output logic [LW-1:0] df);
    logic [LW-1:0] fr;
    pn = 1'b1;
    dn = nx;
    fr = dir ? ln - LW'(FD) : ln + LW'(FD);
    pf = (pg(fr) == pg(ln));
    df = fr;
  endtask

  task automatic modelRef(input logic v, input logic [LW-1:0] ln, input logic m,
                          output logic pn, output logic pf,
                          output logic [LW-1:0] dn, output logic [LW-1:0] df);
    int hi, ai, di, ci, sl;
    logic dup, dir;
    logic [LW-1:0] up, dw, nx;
    pn = 1'b0; pf = 1'b0; dn = '0; df = '0;
    up = ln + LW'(1);
    dw = ln - LW'(1);
    if (v) begin
      hi = -1;
      for (int i = 0; i < NS; i++) if (hi < 0 && mV[i] && mN[i] == ln) hi = i;
      if (hi >= 0) begin
        dir = mD[hi];
        nx = dir ? dw : up;
        if (pg(nx) != pg(ln)) mV[hi] = 1'b0;
        else begin
          mN[hi] = nx;
          mSt[hi] = stampCtr++;
          issue(dir, ln, nx, pn, pf, dn, df);
        end
      end else if (m) begin
        ai = -1; di = -1; dup = 1'b0;
        for (int c = 0; c < NC; c++) if (cV[c]) begin
          if (ai < 0 && cL[c] == dw) ai = c;
          if (di < 0 && cL[c] == up) di = c;
          if (cL[c] == ln) dup = 1'b1;
        end
        if (ai >= 0 || di >= 0) begin
          dir = (ai < 0);
          ci = dir ? di : ai;
          cV[ci] = 1'b0;
          nx = dir ? dw : up;
          if (pg(nx) == pg(ln)) begin
            sl = -1;
            for (int i = 0; i < NS; i++) if (sl < 0 && !mV[i]) sl = i;
            if (sl < 0) begin
              sl = 0;
              for (int i = 1; i < NS; i++) if (mSt[i] < mSt[sl]) sl = i;
            end
            mV[sl] = 1'b1; mN[sl] = nx; mD[sl] = dir; mSt[sl] = stampCtr++;
            issue(dir, ln, nx, pn, pf, dn, df);
          end
        end else if (!dup) begin
          cV[cPtr] = 1'b1;
          cL[cPtr] = ln;
          cPtr = (cPtr + 1) % NC;
        end
      end
    end
  endtask

  task automatic modelQueue(inout logic [LW-1:0] q[2], inout int cnt,
                            input logic rdy, input logic push, input logic [LW-1:0] d);
    logic pop;
    logic canPush;
    pop = (cnt > 0) && rdy;
    canPush = push && (cnt < 2);
    if (pop) begin q[0] = q[1]; cnt--; end
    if (canPush) begin q[cnt] = d; cnt++; end
  endtask

  task automatic step(input logic v, input logic [LW-1:0] ln, input logic m,
                      input logic rn, input logic rf);
    logic pn, pf;
    logic [LW-1:0] dn, df;
    @(negedge clk);
    check(nearValid == (qNc > 0), "nearValid", nearValid, qNc > 0);
    if (qNc > 0) check(nearLine == qN[0], "nearLine", nearLine, qN[0]);
    check(farValid == (qFc > 0), "farValid", farValid, qFc > 0);
    if (qFc > 0) check(farLine == qF[0], "farLine", farLine, qF[0]);
    refValid = v; refLine = ln; refMiss = m; nearReady = rn; farReady = rf;
    modelRef(v, ln, m, pn, pf, dn, df);
    modelQueue(qN, qNc, rn, pn, dn);
    modelQueue(qF, qFc, rf, pf, df);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finishRun();
  end

  logic [LW-1:0] wPos[3];
  logic          wDir[3];

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NS; i++) begin mV[i] = 0; mN[i] = '0; mD[i] = 0; mSt[i] = 0; end
    for (int i = 0; i < NC; i++) begin cV[i] = 0; cL[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);

    // R1: quiet after reset
    curReq = "R1";
    @(negedge clk);
    check(!nearValid, "near after reset", nearValid, 0);
    check(!farValid, "far after reset", farValid, 0);
    idle(2);

    // R2: ascending confirm, then R4 advance
    curReq = "R2";
    step(1, 26'd100, 1, 1, 1);
    step(1, 26'd101, 1, 1, 1);
    idle(2);
    curReq = "R4";
    step(1, 26'd102, 0, 1, 1);
    step(1, 26'd103, 1, 1, 1);
    idle(2);

    // R3: descending confirm, and ascending preferred when both neighbours parked
    curReq = "R3";
    step(1, 26'd300, 1, 1, 1);
    step(1, 26'd299, 1, 1, 1);
    idle(1);
    step(1, 26'd400, 1, 1, 1);
    step(1, 26'd402, 1, 1, 1);
    step(1, 26'd401, 1, 1, 1);
    idle(2);

    // R5: non-miss stray reference has no effect
    curReq = "R5";
    step(1, 26'd500, 0, 1, 1);
    step(1, 26'd501, 1, 1, 1);
    idle(2);

    // R6: page edge on confirm and on advance; R7 far suppression
    curReq = "R6";
    step(1, 26'd190, 1, 1, 1);
    step(1, 26'd191, 1, 1, 1);
    idle(2);
    curReq = "R7";
    step(1, 26'd700, 1, 1, 1);
    step(1, 26'd701, 1, 1, 1);  // next 702, far 713 is in page 11 (704..767)? 701 page 10
    idle(1);
    curReq = "R6";
    step(1, 26'd702, 0, 1, 1);
    step(1, 26'd703, 0, 1, 1);  // next 704 crosses: retire
    step(1, 26'd704, 0, 1, 1);
    idle(2);

    // R8: fill all slots, refresh the oldest, evict by a new stream
    curReq = "R8";
    for (int k = 0; k < 8; k++) begin
      step(1, LW'(2048 + 64 * k), 1, 1, 1);
      step(1, LW'(2049 + 64 * k), 1, 1, 1);
      idle(1);
    end
    step(1, 26'd2050, 0, 1, 1);  // advance the earliest stream of the group
    idle(1);
    step(1, 26'd3000, 1, 1, 1);
    step(1, 26'd3001, 1, 1, 1);
    idle(1);
    step(1, 26'd2114, 0, 1, 1);  // stream that was oldest: evicted, nothing
    step(1, 26'd2051, 0, 1, 1);  // still live
    idle(2);

    // R9: round-robin candidate replacement and duplicates
    curReq = "R9";
    step(1, 26'd4000, 1, 1, 1);
    step(1, 26'd4010, 1, 1, 1);
    step(1, 26'd4010, 1, 1, 1);
    step(1, 26'd4020, 1, 1, 1);
    step(1, 26'd4030, 1, 1, 1);
    step(1, 26'd4040, 1, 1, 1);
    step(1, 26'd4001, 1, 1, 1);
    step(1, 26'd4021, 1, 1, 1);
    idle(2);

    // R10: back-pressure, ordering and drop on a full queue
    curReq = "R10";
    step(1, 26'd6000, 1, 0, 0);
    step(1, 26'd6001, 1, 0, 0);
    step(1, 26'd6002, 0, 0, 0);
    step(1, 26'd6003, 0, 0, 0);
    step(0, '0, 0, 0, 0);
    step(0, '0, 0, 1, 0);
    step(0, '0, 0, 1, 1);
    idle(3);

    // random walks over a few pages, all requirements
    curReq = "R4 random";
    for (int w = 0; w < 3; w++) begin
      wPos[w] = LW'(26'h1000 + $urandom % 256);
      wDir[w] = 1'($urandom % 2);
    end
    for (int n = 0; n < 4000; n++) begin
      int r;
      int w;
      logic [LW-1:0] ln;
      logic v, m;
      r = $urandom % 10;
      v = 1'b1;
      if (r < 6) begin
        w = $urandom % 3;
        wPos[w] = wDir[w] ? wPos[w] - LW'(1) : wPos[w] + LW'(1);
        ln = wPos[w];
        m = ($urandom % 4) != 0;
      end else if (r == 6) begin
        w = $urandom % 3;
        wPos[w] = LW'(26'h1000 + $urandom % 256);
        wDir[w] = 1'($urandom % 2);
        ln = wPos[w];
        m = 1'b1;
      end else if (r < 9) begin
        ln = LW'(26'h1000 + $urandom % 256);
        m = 1'($urandom % 2);
      end else begin
        v = 1'b0;
        ln = '0;
        m = 1'b0;
      end
      step(v, ln, m, ($urandom % 4) != 0, ($urandom % 4) != 0);
    end
    idle(4);
    finishRun();
  end

endmodule